// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in with no clock and no registers. Every bit position has a small partial adder. It forms the bit's propagate (the two operand bits differ) and generate (both operand bits are set), and it forms the sum bit from the propagate and the carry that reaches that bit.

The bits are gathered in groups of four. Each group has a lookahead unit that turns the four propagate/generate pairs and the group's incoming carry into the three carries inside the group. The unit also produces one propagate/generate pair for the whole group. That pair feeds an identical unit one level higher, so propagate and generate information moves up the tree and carries come back down. No product or sum term in any unit has more than four inputs.

A width of 4 bits gives one level, 16 bits gives two levels and 64 bits gives three. Any other width stops elaboration. The whole-adder propagate and generate pair is brought out so that a larger structure can chain the adder.

Top module: `cla_tree`

## Requirements
- R1: `sum` equals the low W bits of A + B + `cin`, for every operand pair and carry-in.
- R2: `cout` equals bit W of A + B + `cin`.
- R3: `grp_p` is 1 exactly when A xor B has every one of its W bits set.
- R4: `grp_g` is 1 exactly when A + B, taken with a carry-in of 0, overflows W bits.
- R5: `grp_p` and `grp_g` are never 1 at the same time.
- R6: `cout` equals `grp_g` OR (`grp_p` AND `cin`). When every position propagates, the carry-in must therefore pass through all W bits to the carry-out.
- R7: The widths 4, 16 and 64 all meet R1 to R6. The same behaviour comes from one, two and three lookahead levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Low W bits of the result |
| cout | output | 1 | Carry out of the top bit |
| grp_p | output | 1 | Propagate for the whole adder |
| grp_g | output | 1 | Generate for the whole adder |

## Verification
The hardest case to reach is a carry-in that must travel through every bit and every group at each level. This needs A xor B to be all ones, and random operands produce that with a probability of 2^-W. The stimulus therefore builds many vectors with B set to the complement of a random A, and some with single positions flipped so that the chain breaks at a random bit or group edge. These vectors are mixed with plain random pairs and with fixed patterns: all ones plus one, zeros, and alternating bits. All three widths see the same vectors at the same time.

// File: rtl/cla_tree.sv
module cla_tree #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         grp_p,
  output logic         grp_g
);
  localparam int LV = (W == 64) ? 3 : (W == 16) ? 2 : 1;

  if (!(W == 4 || W == 16 || W == 64)) begin : g_bad_width
    $error("cla_tree: W must be 4, 16 or 64");
  end

  for (genvar k = 0; k <= LV; k++) begin : up
    localparam int CNT = W >> (2 * k);
    logic [CNT-1:0] p, g;
    if (k == 0) begin : g_bits
      assign p = a ^ b;
      assign g = a & b;
    end else begin : g_grp
      for (genvar u = 0; u < CNT; u++) begin : unit
        logic [3:0] lp, lg;
        assign lp = up[k-1].p[4*u +: 4];
        assign lg = up[k-1].g[4*u +: 4];
        assign p[u] = lp[3] & lp[2] & lp[1] & lp[0];
        assign g[u] = lg[3]
                    | (lp[3] & lg[2])
                    | (lp[3] & lp[2] & lg[1])
                    | (lp[3] & lp[2] & lp[1] & lg[0]);
      end
    end
  end

  for (genvar k = 0; k <= LV; k++) begin : dn
    localparam int CNT = W >> (2 * k);
    logic [CNT-1:0] c;
    if (k == LV) begin : g_root
      assign c = cin;
    end else begin : g_split
      for (genvar u = 0; u < CNT / 4; u++) begin : unit
        logic [3:0] lp, lg;
        logic       c0;
        assign lp = up[k].p[4*u +: 4];
        assign lg = up[k].g[4*u +: 4];
        assign c0 = dn[k+1].c[u];
        assign c[4*u]   = c0;
        assign c[4*u+1] = lg[0] | (lp[0] & c0);
        assign c[4*u+2] = lg[1]
                        | (lp[1] & lg[0])
                        | (lp[1] & lp[0] & c0);
        assign c[4*u+3] = lg[2]
                        | (lp[2] & lg[1])
                        | (lp[2] & lp[1] & lg[0])
                        | (lp[2] & lp[1] & lp[0] & c0);
      end
    end
  end

  assign sum   = up[0].p ^ dn[0].c;
  assign grp_p = up[LV].p[0];
  assign grp_g = up[LV].g[0];
  assign cout  = grp_g | (grp_p & cin);
endmodule

module cla_tree_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         cin,
  input logic [W-1:0] sum,
  input logic         cout,
  input logic         grp_p,
  input logic         grp_g
);
  logic [W:0] total, nocarry;
  assign total   = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign nocarry = {1'b0, a} + {1'b0, b};

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      // R1 R2
      result_chk: assert ({cout, sum} == total);
      // R3
      prop_chk: assert (grp_p == (&(a ^ b)));
      // R4
      gen_chk: assert (grp_g == nocarry[W]);
      // R5
      excl_chk: assert (!(grp_p && grp_g));
      // R6
      carry_rel_chk: assert (cout == (grp_g | (grp_p & cin)));
    end
  end
endmodule

bind cla_tree cla_tree_chk #(.W(W)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum),
  .cout(cout), .grp_p(grp_p), .grp_g(grp_g)
);

// File: tb/tb_cla_tree.sv
module tb_cla_tree;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [63:0] a64, b64;
  logic        cin;

  logic [63:0] s64; logic co64, p64, g64;
  logic [15:0] s16; logic co16, p16, g16;
  logic [3:0]  s4;  logic co4,  p4,  g4;

  cla_tree #(.W(64)) dut   (.a(a64),       .b(b64),       .cin(cin), .sum(s64), .cout(co64), .grp_p(p64), .grp_g(g64));
  cla_tree #(.W(16)) dut16 (.a(a64[15:0]), .b(b64[15:0]), .cin(cin), .sum(s16), .cout(co16), .grp_p(p16), .grp_g(g16));
  cla_tree #(.W(4))  dut4  (.a(a64[3:0]),  .b(b64[3:0]),  .cin(cin), .sum(s4),  .cout(co4),  .grp_p(p4),  .grp_g(g4));

  function automatic logic [64:0] ref_add(logic [63:0] x, logic [63:0] y, logic c, int w);
    logic [64:0] msk, r;
    msk = (65'd1 << w) - 65'd1;
    r = ({1'b0, x} & msk) + ({1'b0, y} & msk) + {64'd0, c};
    return r & ((65'd1 << (w + 1)) - 65'd1);
  endfunction

  task automatic chk(string req, int w, logic [64:0] act, logic [64:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s W=%0d a=%h b=%h cin=%0d actual=%h expected=%h",
               req, w, a64, b64, cin, act, exp);
    end
  endtask

  task automatic check_width(int w, logic [63:0] s, logic co, logic p, logic g);
    logic [64:0] tot, nc, msk;
    logic ep, eg;
    msk = (65'd1 << w) - 65'd1;
    tot = ref_add(a64, b64, cin, w);
    nc  = ref_add(a64, b64, 1'b0, w);
    ep  = ((({1'b0, a64} ^ {1'b0, b64}) & msk) == msk);
    eg  = nc[w];
    // R1 R7: sum at each width
    chk("R1", w, {1'b0, s} & msk, tot & msk);
    // R2
    chk("R2", w, {64'd0, co}, {64'd0, tot[w]});
    // R3
    chk("R3", w, {64'd0, p}, {64'd0, ep});
    // R4
    chk("R4", w, {64'd0, g}, {64'd0, eg});
    // R5
    chk("R5", w, {64'd0, p & g}, 65'd0);
    // R6
    chk("R6", w, {64'd0, co}, {64'd0, g | (p & cin)});
  endtask

  task automatic apply(logic [63:0] x, logic [63:0] y, logic c);
    @(negedge clk);
    a64 = x; b64 = y; cin = c;
    #1;
    check_width(64, s64, co64, p64, g64);
    check_width(16, {48'd0, s16}, co16, p16, g16);
    check_width(4,  {60'd0, s4},  co4,  p4,  g4);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] x, y;
    a64 = '0; b64 = '0; cin = 1'b0;
    void'($urandom(32'h1cad_5eed));
    // reset-like idle state: zero plus zero
    apply(64'd0, 64'd0, 1'b0);
    apply(64'd0, 64'd0, 1'b1);
    // all ones plus one, both carry-in forms (R2 R6 full ripple)
    apply('1, 64'd1, 1'b0);
    apply('1, 64'd0, 1'b1);
    apply('1, '1, 1'b1);
    // alternating bit patterns
    apply({16{4'h5}}, {16{4'hA}}, 1'b0);
    apply({16{4'h5}}, {16{4'hA}}, 1'b1);
    apply({16{4'hA}}, {16{4'hA}}, 1'b0);
    apply({16{4'h5}}, {16{4'h5}}, 1'b1);
    // full-propagate chains and chains broken at a random position
    for (int i = 0; i < 600; i++) begin
      x = {$urandom(), $urandom()};
      y = ~x;
      if (i % 2 == 1) y[$urandom_range(63, 0)] ^= 1'b1;
      apply(x, y, 1'($urandom_range(1, 0)));
    end
    // plain random operands
    for (int i = 0; i < 1500; i++) begin
      x = {$urandom(), $urandom()};
      y = {$urandom(), $urandom()};
      apply(x, y, 1'($urandom_range(1, 0)));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule